// File: doc/BRIEF.md
# Radix-8 Booth Recoded Signed Multiplier

This block multiplies two signed two's-complement operands of `N` bits each and returns the exact `2N`-bit signed product. The multiplier operand `b` gets a zero appended below its least significant bit and is sign-extended upward. It is then cut into overlapping 4-bit windows. Each window starts 3 bit positions above the previous one and shares one bit with it. Each window is recoded into a digit from −4 to +4. Row `k` holds that digit times the multiplicand `a` and is weighted by `8^k`. This gives `ceil(N/3)` rows instead of `N`.

The odd multiple 3·a is formed once, with one carry-propagate adder, and every row shares it. The multiples 2·a and 4·a are plain shifts. A negative digit inverts the selected multiple, and a one is injected at the row's lowest weight. The rows and the injected ones are then summed into the product.

The parameter `OUT_REG` chooses the variant. With `OUT_REG=1` the product is captured in a register on a cycle where `in_valid` is high, appears one cycle later and is then held. With `OUT_REG=0` the product is purely combinational and `out_valid` simply mirrors `in_valid`. There is no state machine; the only state is the optional output register.

Top module: `booth8_mult`

## Requirements
- R1: For every pair of signed operands, `product` equals the exact signed product `a*b` represented in 2N bits.
- R2: Each window {b[3k+2], b[3k+1], b[3k], b[3k-1]} (with b[-1]=0) selects a digit: 0000 and 1111 give 0; 0001 and 0010 give +1; 0011 and 0100 give +2; 0101 and 0110 give +3; 0111 gives +4; 1000 gives −4; 1001 and 1010 give −3; 1011 and 1100 give −2; 1101 and 1110 give −1. Row k carries weight 8^k.
- R3: The extremes are exact. In particular (−2^(N−1))·(−2^(N−1)) = 2^(2N−2), and every product with a most-negative or most-positive operand is exact.
- R4: A negative multiplier is sign-extended into the top window, so b = −1 and b = −2^(N−1) give −a and −a·2^(N−1).
- R5: With OUT_REG=1, if `in_valid` is high at a rising edge, then after that edge `out_valid` is 1 and `product` holds the product of the operands sampled at that edge.
- R6: With OUT_REG=1, if `in_valid` is low at a rising edge, then after that edge `out_valid` is 0 and `product` is unchanged, whatever `a` and `b` carry.
- R7: With OUT_REG=1, while `rst_n` is low, `product` is 0 and `out_valid` is 0.
- R8: With OUT_REG=0, `product` follows `a` and `b` combinationally and `out_valid` equals `in_valid`.
- R9: A zero operand on either side yields a zero product.
- R10: When both operands are nonzero, the most significant product bit equals the XOR of the operand sign bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on `a` and `b` are to be used |
| a | input | N | Signed multiplicand |
| b | input | N | Signed multiplier (recoded operand) |
| out_valid | output | 1 | `product` carries a fresh result |
| product | output | 2N | Signed product |

## Verification
The bench sweeps all 65,536 operand pairs at N=8. That sweep reaches every window code, including the lone −4 pattern 1000, which a faulty recoder would mix up with −3 or 0. At N=16 it drives the most negative operand squared, where a row kept too narrow for ±4·a or a missing top window would give a wrong sign or drop 2^30. It also drives all-ones and most-negative multipliers, which go wrong if the multiplier is zero-extended instead of sign-extended. A missing negation one shows up as an off-by-8^k error on every negative digit. A register that loads while `in_valid` is low shows up as a changed product on the idle cycle that follows each result.

// File: rtl/booth8_pkg.sv
package booth8_pkg;

    typedef enum logic [2:0] {
        MAG_ZERO  = 3'd0,
        MAG_ONE   = 3'd1,
        MAG_TWO   = 3'd2,
        MAG_THREE = 3'd3,
        MAG_FOUR  = 3'd4
    } mag_e;

    typedef struct packed {
        logic neg;
        mag_e mag;
    } digit_t;

endpackage

// File: rtl/booth8_recoder.sv
module booth8_recoder
    import booth8_pkg::*;
#(
    parameter int N    = 16,
    parameter int ROWS = (N + 2) / 3
) (
    input  logic [N-1:0]              mult,
    output digit_t [ROWS-1:0]         digits
);
    localparam int MX_W = 3 * ROWS;

    logic signed [MX_W-1:0] mult_sx;
    logic [MX_W:0]          ext;

    assign mult_sx = MX_W'($signed(mult));
    assign ext     = {mult_sx, 1'b0};

    for (genvar k = 0; k < ROWS; k++) begin : g_win
        logic [3:0] win;
        assign win = ext[3*k +: 4];

        always_comb begin
            unique case (win)
                4'b0000, 4'b1111: digits[k] = '{neg: 1'b0, mag: MAG_ZERO};
                4'b0001, 4'b0010: digits[k] = '{neg: 1'b0, mag: MAG_ONE};
                4'b0011, 4'b0100: digits[k] = '{neg: 1'b0, mag: MAG_TWO};
                4'b0101, 4'b0110: digits[k] = '{neg: 1'b0, mag: MAG_THREE};
                4'b0111:          digits[k] = '{neg: 1'b0, mag: MAG_FOUR};
                4'b1000:          digits[k] = '{neg: 1'b1, mag: MAG_FOUR};
                4'b1001, 4'b1010: digits[k] = '{neg: 1'b1, mag: MAG_THREE};
                4'b1011, 4'b1100: digits[k] = '{neg: 1'b1, mag: MAG_TWO};
                default:          digits[k] = '{neg: 1'b1, mag: MAG_ONE};
            endcase
        end
    end

endmodule

// File: rtl/booth8_triple.sv
module booth8_triple #(
    parameter int N = 16
) (
    input  logic signed [N-1:0] m,
    output logic signed [N+1:0] m3
);
    localparam int TW = N + 2;

    logic signed [TW-1:0] m_sx;

    assign m_sx = TW'(m);
    assign m3   = m_sx + (m_sx <<< 1);

endmodule

// File: rtl/booth8_row.sv
module booth8_row
    import booth8_pkg::*;
#(
    parameter int N  = 16,
    parameter int RW = N + 3
) (
    input  logic signed [N-1:0]  m,
    input  logic signed [N+1:0]  m3,
    input  digit_t               dig,
    output logic [RW-1:0]        row
);
    logic signed [RW-1:0] m_x;
    logic signed [RW-1:0] m3_x;
    logic [RW-1:0]        pick;

    assign m_x  = RW'(m);
    assign m3_x = RW'(m3);

    always_comb begin
        unique case (dig.mag)
            MAG_ONE:   pick = m_x;
            MAG_TWO:   pick = m_x <<< 1;
            MAG_THREE: pick = m3_x;
            MAG_FOUR:  pick = m_x <<< 2;
            default:   pick = '0;
        endcase
        row = dig.neg ? ~pick : pick;
    end

endmodule

// File: rtl/booth8_mult.sv
module booth8_mult
    import booth8_pkg::*;
#(
    parameter int N       = 16,
    parameter bit OUT_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [N-1:0]      a,
    input  logic [N-1:0]      b,
    output logic              out_valid,
    output logic [2*N-1:0]    product
);
    localparam int ROWS = (N + 2) / 3;
    localparam int RW   = N + 3;
    localparam int PW   = 2 * N;

    digit_t [ROWS-1:0]        digits;
    logic signed [N+1:0]      a3;
    logic [ROWS-1:0][RW-1:0]  rows;
    logic [PW-1:0]            sum;

    booth8_recoder #(.N(N), .ROWS(ROWS)) recoder_i (
        .mult   (b),
        .digits (digits)
    );

    booth8_triple #(.N(N)) triple_i (
        .m  ($signed(a)),
        .m3 (a3)
    );

    for (genvar k = 0; k < ROWS; k++) begin : g_row
        booth8_row #(.N(N), .RW(RW)) row_i (
            .m   ($signed(a)),
            .m3  (a3),
            .dig (digits[k]),
            .row (rows[k])
        );
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < ROWS; k++) begin
            sum = sum + (PW'($signed(rows[k])) << (3 * k));
            sum = sum + (PW'(digits[k].neg) << (3 * k));
        end
    end

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                product   <= '0;
                out_valid <= 1'b0;
            end else begin
                out_valid <= in_valid;
                if (in_valid) begin
                    product <= sum;
                end
            end
        end
    end else begin : g_comb
        assign product   = sum;
        assign out_valid = in_valid;
    end

endmodule

// File: rtl/booth8_mult_chk.sv
module booth8_mult_chk #(
    parameter int N       = 16,
    parameter bit OUT_REG = 1'b1
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [N-1:0]    a,
    input logic [N-1:0]    b,
    input logic            out_valid,
    input logic [2*N-1:0]  product
);
    localparam int PW = 2 * N;

    if (OUT_REG) begin : g_reg_chk
        AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid);  // R5
        AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> !out_valid);  // R6
        AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> $stable(product));  // R6
        AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (a == '0 || b == '0)) |=> (product == '0));  // R9
        AST_PRODUCT_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && a != '0 && b != '0) |=>
            (product[PW-1] == ($past(a[N-1]) ^ $past(b[N-1]))));  // R10
        AST_UNIT_MULTIPLIER: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && b == N'(1)) |=> (product == PW'($signed($past(a)))));  // R1
        always @(posedge clk) begin
            if (!rst_n) begin
                AST_RESET_CLEAR: assert (out_valid == 1'b0 && product == '0);  // R7
            end
        end
    end else begin : g_comb_chk
        AST_COMB_VALID: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);  // R8
        AST_COMB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            (a == '0 || b == '0) |-> (product == '0));  // R9
        AST_COMB_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
            (a != '0 && b != '0) |-> (product[PW-1] == (a[N-1] ^ b[N-1])));  // R10
    end

endmodule

bind booth8_mult booth8_mult_chk #(.N(N), .OUT_REG(OUT_REG)) chk_i (.*);

// File: tb/booth8_mult_tb_top.sv
module booth8_mult_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done = 1'b0;
    int          n_chk = 0;
    int          n_bad = 0;

    logic        v16 = 1'b0;
    logic [15:0] a16 = '0;
    logic [15:0] b16 = '0;
    logic        ov16;
    logic [31:0] p16;

    logic        v8 = 1'b0;
    logic [7:0]  a8 = '0;
    logic [7:0]  b8 = '0;
    logic        ov8;
    logic [15:0] p8;

    always #2 clk = ~clk;

    booth8_mult #(.N(16), .OUT_REG(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(v16), .a(a16), .b(b16),
        .out_valid(ov16), .product(p16)
    );

    booth8_mult #(.N(8), .OUT_REG(1'b0)) dut_n8_i (
        .clk(clk), .rst_n(rst_n), .in_valid(v8), .a(a8), .b(b8),
        .out_valid(ov8), .product(p8)
    );

    function automatic longint ref_mul16(logic [15:0] x, logic [15:0] y);
        return longint'($signed(x)) * longint'($signed(y));
    endfunction

    function automatic longint ref_mul8(logic [7:0] x, logic [7:0] y);
        return longint'($signed(x)) * longint'($signed(y));
    endfunction

    task automatic check(string req, longint act, longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (a16=%h b16=%h a8=%h b8=%h)",
                     req, act, exp, a16, b16, a8, b8);
        end
    endtask

    // One registered multiply, then one idle cycle with disturbed operands.
    task automatic run16(string req, logic [15:0] x, logic [15:0] y);
        longint exp;
        exp = ref_mul16(x, y);
        @(negedge clk);
        a16 = x; b16 = y; v16 = 1'b1;
        @(negedge clk);
        v16 = 1'b0;
        check("R5 out_valid", longint'(ov16), 1);
        check(req, longint'($signed(p16)), exp);
        if (x != 0 && y != 0)
            check("R10 sign", longint'(p16[31]), longint'(x[15] ^ y[15]));
        a16 = ~x; b16 = y + 16'd77;
        @(negedge clk);
        check("R6 idle out_valid", longint'(ov16), 0);
        check("R6 idle hold", longint'($signed(p16)), exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R7 reset valid", longint'(ov16), 0);
        check("R7 reset product", longint'(p16), 0);
        a16 = 16'h1234; b16 = 16'h0567; v16 = 1'b1;
        @(negedge clk);
        check("R7 reset held valid", longint'(ov16), 0);
        check("R7 reset held product", longint'(p16), 0);
        v16 = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        // R9 zero operands
        run16("R9", 16'd0, 16'd12345);
        run16("R9", 16'hFFF9, 16'd0);
        // R3 extremes
        run16("R3", 16'h8000, 16'h8000);
        run16("R3", 16'h8000, 16'h7FFF);
        run16("R3", 16'h7FFF, 16'h7FFF);
        run16("R3", 16'h7FFF, 16'h8000);
        run16("R3", 16'h8000, 16'h0001);
        // R4 negative multipliers needing sign extension
        run16("R4", 16'd12345, 16'hFFFF);
        run16("R4", 16'd12345, 16'h8000);
        run16("R4", 16'h8001, 16'hAAAA);
        // R2 digit sweep in the lowest windows
        for (int d = -4; d <= 4; d++) begin
            run16("R2", 16'd1234, 16'(d));
            run16("R2", 16'hFFFF, 16'(d));
        end
        run16("R2", 16'h4321, 16'h0777);
        run16("R2", 16'h4321, 16'h0888);
        // R1 random vectors with a fixed seed
        begin
            logic [15:0] ra;
            logic [15:0] rb;
            ra = 16'($urandom(32'h00C0FFEE));
            for (int i = 0; i < 2000; i++) begin
                ra = 16'($urandom());
                rb = 16'($urandom());
                run16("R1", ra, rb);
            end
        end

        // R1/R8 exhaustive sweep of the combinational 8-bit variant
        @(negedge clk);
        v8 = 1'b1;
        #1;
        check("R8 out_valid high", longint'(ov8), 1);
        for (int i = 0; i < 65536; i++) begin
            a8 = i[7:0];
            b8 = i[15:8];
            #1;
            check("R1 n8", longint'($signed(p8)), ref_mul8(i[7:0], i[15:8]));
        end
        v8 = 1'b0;
        #1;
        check("R8 out_valid low", longint'(ov8), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule